// File: doc/BRIEF.md
# Multi-Source Chip Reset Controller

This block merges the chip-wide reset and power-fail causes into the reset and power-down controls for two domains, the processor core and the correlator. It watches three inputs: the external reset pin, a front-end PLL lock line, and a supply power-good line. The lock line and the power-good line are both active low. Each monitored source goes through its own synchroniser. Each source can also be masked from causing a reset by an enable bit in a small register interface.

A supply failure can also raise a power-down request when a separate enable bit in a second register is set. That request covers every function except the real-time clock and the retention register. The lock line is also passed to the interrupt controller as a request line, and this happens whatever the reset mask says.

When the supply comes back, power-good may rise milliseconds before the PLL locks. For this reason the reset stays asserted until every enabled source is inactive. After that it is held for a programmable number of further clock cycles. A status register shows the live synchronised source levels and sticky flags that record which source caused a reset.

Top module: `chip_rst_ctrl`

## Requirements
- R1: With the lock-reset enable (status register bit 0) at 1, a low level on `pll_locked` drives `core_rst_n` low at the third rising clock edge after the input falls, and not earlier.
- R2: With status register bit 0 at 0, a low `pll_locked` leaves `core_rst_n` and `corr_rst_n` high.
- R3: With the supply-reset enable (status register bit 1) at 1, a low level on `pwr_ok` drives both reset outputs low at the third rising edge after the input falls.
- R4: With status register bit 1 at 0, a low `pwr_ok` leaves both reset outputs high.
- R5: `pll_irq` is high exactly when the lock line, delayed by two clock edges, is low. The lock-reset enable has no effect on it.
- R6: `pdn_req` goes high two edges after `pwr_ok` falls, but only while power-control register bit 15 is 1. With that bit at 0, `pdn_req` stays low.
- R7: Reset stays asserted while any enabled source is active. After the last active source goes high, both reset outputs go high at the edge `HOLD_CYCLES`+2 after that input rises.
- R8: A low `ext_rst_n` drives both reset outputs low at once, with no clock edge needed. It sets the status register to 0x0003 plus the live level bits and sets the power-control register to 0x8000. Reset is released at the `HOLD_CYCLES`-th edge after the pin rises.
- R9: Status register bits 4 and 5 read the synchronised live levels of `pll_locked` and `pwr_ok`.
- R10: Status bit 8 (lock-loss cause) and bit 9 (supply-fail cause) set while their source is active and enabled. They stay set after the source clears. Writing 1 to a flag clears it.
- R11: `core_rst_n` and `corr_rst_n` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| pll_locked | input | 1 | Front-end PLL lock, low means unlocked |
| pwr_ok | input | 1 | Supply power-good, low means supply failure |
| reg_sel | input | 1 | Register select: 0 status/enable, 1 power control |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| core_rst_n | output | 1 | Processor core reset, active low |
| corr_rst_n | output | 1 | Correlator reset, active low |
| pdn_req | output | 1 | Power-down request, spares the RTC and retention domain |
| pll_irq | output | 1 | Lock-loss interrupt request line |

## Verification
Each source is lowered on its own, with its enable set and then cleared. This separates the reset path from the mask, and the interrupt line from the reset enable. The power-up ordering case lowers both sources, raises power-good first and holds lock low for a long time. This shows the release waits for the last enabled source and then counts the full hold, rather than releasing when either source clears. Edge-exact sampling on assertion and release tells a correct synchroniser and hold depth apart from one that is a cycle short or long. A pin reset pulse dropped between clock edges shows that assertion does not wait for the clock.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   localparam int NUM_SRC   = 2;
   localparam int SRC_PLL   = 0;
   localparam int SRC_PWR   = 1;
   localparam int EN_LSB    = 0;
   localparam int LIVE_LSB  = 4;
   localparam int CAUSE_LSB = 8;
   localparam int PDN_BIT   = 15;

   typedef enum logic {
      SEL_STAT = 1'b0,
      SEL_PWR  = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= 1'b1;
               else        pipe[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= 1'b1;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/rstc_hold.sv
module rstc_hold #(
   parameter int HOLD_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic rel_n
);
   localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

   logic [CNT_W-1:0] cnt;
   logic             rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         rel_q <= 1'b0;
      end else if (req) begin
         cnt   <= '0;
         rel_q <= 1'b0;
      end else if (!rel_q) begin
         if (cnt == LAST) rel_q <= 1'b1;
         else             cnt   <= cnt + 1'b1;
      end
   end

   assign rel_n = rel_q;
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
   import rstc_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel,
   input  logic               we,
   input  logic [REG_W-1:0]   wdata,
   input  logic [NUM_SRC-1:0] live,
   output logic [NUM_SRC-1:0] src_en,
   output logic               pdn_en,
   output logic [REG_W-1:0]   rdata
);
   logic [NUM_SRC-1:0] cause;
   logic               wr_stat;
   logic               wr_pwr;
   logic               unused_wdata;

   assign wr_stat      = we && (sel == SEL_STAT);
   assign wr_pwr       = we && (sel == SEL_PWR);
   assign unused_wdata = ^wdata;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               src_en[i] <= 1'b1;
            end else if (wr_stat) begin
               src_en[i] <= wdata[EN_LSB + i];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cause[i] <= 1'b0;
            end else if (!live[i] && src_en[i]) begin
               cause[i] <= 1'b1;
            end else if (wr_stat && wdata[CAUSE_LSB + i]) begin
               cause[i] <= 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pdn_en <= 1'b1;
      else if (wr_pwr) pdn_en <= wdata[PDN_BIT];
   end

   always_comb begin
      rdata = '0;
      if (sel == SEL_STAT) begin
         rdata[EN_LSB    +: NUM_SRC] = src_en;
         rdata[LIVE_LSB  +: NUM_SRC] = live;
         rdata[CAUSE_LSB +: NUM_SRC] = cause;
      end else begin
         rdata[PDN_BIT] = pdn_en;
      end
   end
endmodule

// File: rtl/chip_rst_ctrl.sv
module chip_rst_ctrl
   import rstc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 16,
   parameter int REG_W       = 16
) (
   input  logic             clk,
   input  logic             ext_rst_n,
   input  logic             pll_locked,
   input  logic             pwr_ok,
   input  logic             reg_sel,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             core_rst_n,
   output logic             corr_rst_n,
   output logic             pdn_req,
   output logic             pll_irq
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
      if (REG_W < PDN_BIT + 1) begin : g_bad_w
         $error("REG_W too narrow for the power-down enable bit");
      end
   endgenerate

   logic [NUM_SRC-1:0] raw;
   logic [NUM_SRC-1:0] live;
   logic [NUM_SRC-1:0] src_en;
   logic               pdn_en;
   logic               rst_req;
   logic               rel_n;

   assign raw[SRC_PLL] = pll_locked;
   assign raw[SRC_PWR] = pwr_ok;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
         rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (ext_rst_n),
            .d     (raw[i]),
            .q     (live[i])
         );
      end
   endgenerate

   rstc_regs #(.REG_W(REG_W)) u_regs (
      .clk    (clk),
      .rst_n  (ext_rst_n),
      .sel    (reg_sel),
      .we     (reg_we),
      .wdata  (reg_wdata),
      .live   (live),
      .src_en (src_en),
      .pdn_en (pdn_en),
      .rdata  (reg_rdata)
   );

   assign rst_req = |(~live & src_en);

   rstc_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk   (clk),
      .rst_n (ext_rst_n),
      .req   (rst_req),
      .rel_n (rel_n)
   );

   assign core_rst_n = rel_n;
   assign corr_rst_n = rel_n;
   assign pdn_req    = pdn_en & ~live[SRC_PWR];
   assign pll_irq    = ~live[SRC_PLL];
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
   parameter int HOLD_CYCLES = 16
) (
   input logic clk,
   input logic ext_rst_n,
   input logic pll_locked,
   input logic pwr_ok,
   input logic pll_s,
   input logic pwr_s,
   input logic en_pll,
   input logic en_pwr,
   input logic pdn_en,
   input logic core_rst_n,
   input logic corr_rst_n,
   input logic pdn_req,
   input logic pll_irq
);
   localparam int QW = $clog2(HOLD_CYCLES + 1) + 1;

   logic [1:0]    cyc;
   logic [QW-1:0] quiet;
   logic          req_seen;

   assign req_seen = (!pll_s && en_pll) || (!pwr_s && en_pwr);

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         cyc   <= '0;
         quiet <= '0;
      end else begin
         if (cyc != 2'd3) cyc <= cyc + 1'b1;
         if (req_seen)                     quiet <= '0;
         else if (quiet < QW'(HOLD_CYCLES)) quiet <= quiet + 1'b1;
      end
   end

   a_r1_pll_asserts: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (!pll_s && en_pll) |=> !core_rst_n);

   a_r3_pwr_asserts: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (!pwr_s && en_pwr) |=> !core_rst_n);

   a_r5_irq_follows: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (cyc >= 2'd2) |-> (pll_irq == !$past(pll_locked, 2)));

   a_r6_pdn_follows: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (cyc >= 2'd2) |-> (pdn_req == (pdn_en && !$past(pwr_ok, 2))));

   a_r7_hold_min: assert property (@(posedge clk) disable iff (!ext_rst_n)
      core_rst_n |-> (quiet >= QW'(HOLD_CYCLES)));

   a_r11_domains_equal: assert property (@(posedge clk) disable iff (!ext_rst_n)
      core_rst_n == corr_rst_n);
endmodule

bind chip_rst_ctrl rstc_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_rstc_checker (
   .clk        (clk),
   .ext_rst_n  (ext_rst_n),
   .pll_locked (pll_locked),
   .pwr_ok     (pwr_ok),
   .pll_s      (live[0]),
   .pwr_s      (live[1]),
   .en_pll     (src_en[0]),
   .en_pwr     (src_en[1]),
   .pdn_en     (pdn_en),
   .core_rst_n (core_rst_n),
   .corr_rst_n (corr_rst_n),
   .pdn_req    (pdn_req),
   .pll_irq    (pll_irq)
);

// File: tb/chip_rst_ctrl_bench.sv
module chip_rst_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 16;
   localparam int W          = 16;

   logic         clk = 1'b0;
   logic         ext_rst_n = 1'b0;
   logic         pll_locked = 1'b1;
   logic         pwr_ok = 1'b1;
   logic         reg_sel = 1'b0;
   logic         reg_we = 1'b0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         core_rst_n, corr_rst_n, pdn_req, pll_irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chip_rst_ctrl #(.HOLD_CYCLES(HOLD), .REG_W(W)) u_chip_rst_ctrl (
      .clk        (clk),
      .ext_rst_n  (ext_rst_n),
      .pll_locked (pll_locked),
      .pwr_ok     (pwr_ok),
      .reg_sel    (reg_sel),
      .reg_we     (reg_we),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .core_rst_n (core_rst_n),
      .corr_rst_n (corr_rst_n),
      .pdn_req    (pdn_req),
      .pll_irq    (pll_irq)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic sel, input logic [W-1:0] data);
      reg_sel = sel; reg_wdata = data; reg_we = 1'b1;
      tick(1);
      reg_we = 1'b0; reg_sel = 1'b0;
   endtask

   task automatic reg_read(input logic sel, output logic [W-1:0] data);
      reg_sel = sel;
      #1;
      data = reg_rdata;
      reg_sel = 1'b0;
   endtask

   task automatic t_pin_reset;
      logic [W-1:0] d;
      check("R8 reset core low", {15'd0, core_rst_n}, 16'd0);
      check("R11 reset corr low", {15'd0, corr_rst_n}, 16'd0);
      ext_rst_n = 1'b1;
      reg_read(1'b0, d);
      check("R8 status after reset", d, 16'h0033);
      reg_read(1'b1, d);
      check("R8 power reg after reset", d, 16'h8000);
      tick(HOLD - 1);
      check("R8 held before count", {15'd0, core_rst_n}, 16'd0);
      tick(1);
      check("R8 released after count", {15'd0, core_rst_n}, 16'd1);
      check("R11 corr released", {15'd0, corr_rst_n}, 16'd1);
   endtask

   task automatic t_pll_reset;
      logic [W-1:0] d;
      pll_locked = 1'b0;
      tick(2);
      check("R1 not yet asserted", {15'd0, core_rst_n}, 16'd1);
      check("R5 irq raised", {15'd0, pll_irq}, 16'd1);
      reg_read(1'b0, d);
      check("R9 live pll low", {15'd0, d[4]}, 16'd0);
      tick(1);
      check("R1 core asserted", {15'd0, core_rst_n}, 16'd0);
      check("R11 corr asserted", {15'd0, corr_rst_n}, 16'd0);
      pll_locked = 1'b1;
      tick(HOLD + 1);
      check("R7 held after pll return", {15'd0, core_rst_n}, 16'd0);
      tick(1);
      check("R7 released", {15'd0, core_rst_n}, 16'd1);
      check("R5 irq cleared", {15'd0, pll_irq}, 16'd0);
      reg_read(1'b0, d);
      check("R10 pll cause sticky", {15'd0, d[8]}, 16'd1);
      reg_write(1'b0, 16'h0103);
      reg_read(1'b0, d);
      check("R10 pll cause cleared", d, 16'h0033);
   endtask

   task automatic t_pll_masked;
      logic [W-1:0] d;
      reg_write(1'b0, 16'h0002);
      pll_locked = 1'b0;
      tick(6);
      check("R2 masked pll no reset", {15'd0, core_rst_n}, 16'd1);
      check("R5 irq despite mask", {15'd0, pll_irq}, 16'd1);
      reg_read(1'b0, d);
      check("R2 status masked", d, 16'h0022);
      pll_locked = 1'b1;
      tick(3);
      reg_write(1'b0, 16'h0003);
   endtask

   task automatic t_pwr_reset;
      logic [W-1:0] d;
      pwr_ok = 1'b0;
      tick(2);
      check("R6 pdn raised", {15'd0, pdn_req}, 16'd1);
      check("R3 not yet asserted", {15'd0, core_rst_n}, 16'd1);
      reg_read(1'b0, d);
      check("R9 live pwr low", {15'd0, d[5]}, 16'd0);
      tick(1);
      check("R3 core asserted", {15'd0, core_rst_n}, 16'd0);
      check("R3 corr asserted", {15'd0, corr_rst_n}, 16'd0);
      pwr_ok = 1'b1;
      tick(HOLD + 2);
      check("R7 pwr release", {15'd0, core_rst_n}, 16'd1);
      check("R6 pdn dropped", {15'd0, pdn_req}, 16'd0);
      reg_read(1'b0, d);
      check("R10 pwr cause sticky", d[9:8], 16'd2);
      reg_write(1'b0, 16'h0203);
   endtask

   task automatic t_pwr_masked;
      logic [W-1:0] d;
      reg_write(1'b0, 16'h0001);
      pwr_ok = 1'b0;
      tick(6);
      check("R4 masked pwr no reset", {15'd0, core_rst_n}, 16'd1);
      check("R6 pdn with enable", {15'd0, pdn_req}, 16'd1);
      reg_write(1'b1, 16'h0000);
      check("R6 pdn disabled", {15'd0, pdn_req}, 16'd0);
      reg_read(1'b0, d);
      check("R10 masked no cause", d[9:8], 16'd0);
      pwr_ok = 1'b1;
      tick(3);
      reg_write(1'b0, 16'h0003);
      reg_write(1'b1, 16'h8000);
   endtask

   task automatic t_powerup_order;
      pwr_ok = 1'b0;
      pll_locked = 1'b0;
      tick(5);
      pwr_ok = 1'b1;
      tick(40);
      check("R7 held while pll unlocked", {15'd0, core_rst_n}, 16'd0);
      pll_locked = 1'b1;
      tick(HOLD + 1);
      check("R7 held full count", {15'd0, core_rst_n}, 16'd0);
      tick(1);
      check("R7 released after last source", {15'd0, core_rst_n}, 16'd1);
      reg_write(1'b0, 16'h0303);
   endtask

   task automatic t_async_pin;
      #(CLK_PERIOD/4);
      ext_rst_n = 1'b0;
      #1;
      check("R8 async assert", {15'd0, core_rst_n}, 16'd0);
      tick(1);
      ext_rst_n = 1'b1;
      tick(HOLD);
      check("R8 release after pulse", {15'd0, core_rst_n}, 16'd1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      tick(2);
      t_pin_reset();
      t_pll_reset();
      t_pll_masked();
      t_pwr_reset();
      t_pwr_masked();
      t_powerup_order();
      t_async_pin();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule